// File: doc/BRIEF.md
# Synchronous Clock Stop Gating

This block takes one source clock per domain (a CPU domain and a PCI domain) and fans it out to a group of gated clock outputs. Each output has its own enable bit, normally driven from a control register. Each domain also has a group-wide stop request, which is active low. A single tristate request drops the output-enables of every output, so the pads go to high impedance.

Every request is carried into the domain it controls through its own two-flop synchronizer. The gating itself uses a latch that is transparent while the source clock is low. As a result, an output only stops or starts between two high phases: a stopped output parks low, and a restarted output begins with a whole high phase.

The PCI group has one extra output that is free-running. It follows only its own enable and ignores the PCI stop request. Stop requests take effect only when the stop function has been strapped in (strap low) and the stop valid flag is high. With the strap high, the stop pins are treated as deasserted.

Top module: `clk_stop_gate`

## Requirements
- R1: A request value sampled at rising edge n of a domain's clock governs that domain's gated outputs during the high phase that follows rising edge n+2. An output whose enable bit (1 = run) was 0 stays low during that high phase, and an output whose enable bit was 1 is high during it.
- R2: When the CPU stop is honoured and `cpu_stop_ni` is 0, all CPU outputs are low with the R1 timing. The PCI outputs are not affected.
- R3: When the PCI stop is honoured and `pci_stop_ni` is 0, all regular PCI outputs are low with the R1 timing. The CPU outputs are not affected.
- R4: The free-running PCI output follows only `pci_free_en_i`, using the R1 timing, and ignores the PCI stop request.
- R5: While `mode_strap_i` is 1, both stop inputs have no effect, whatever their levels.
- R6: While `stop_vld_i` is 0, both stop inputs have no effect.
- R7: Every gated output is low whenever its source clock is low, so no partial pulse can appear.
- R8: A tristate value sampled at rising edge n sets the output-enables from rising edge n+1 onward. A value of 1 drives every output-enable low, and a value of 0 drives every output-enable high.
- R9: During reset, all gated outputs are low and all output-enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU domain source clock |
| pci_clk_i | input | 1 | PCI domain source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_strap_i | input | 1 | Latched strap; 0 enables the stop inputs |
| stop_vld_i | input | 1 | Stop inputs are valid |
| cpu_stop_ni | input | 1 | CPU group stop request, active low |
| pci_stop_ni | input | 1 | PCI group stop request, active low |
| tristate_i | input | 1 | Places all outputs in high impedance |
| cpu_en_i | input | CPU_N | Per-output CPU enables |
| pci_en_i | input | PCI_N | Per-output PCI enables |
| pci_free_en_i | input | 1 | Enable of the free-running PCI output |
| cpu_clk_o | output | CPU_N | Gated CPU clocks |
| cpu_oe_o | output | CPU_N | CPU output-enables |
| pci_clk_o | output | PCI_N | Gated PCI clocks |
| pci_oe_o | output | PCI_N | PCI output-enables |
| pci_free_clk_o | output | 1 | Free-running PCI clock |
| pci_free_oe_o | output | 1 | Free-running PCI output-enable |

## Verification
The assertions assume that every control input is quasi-static relative to both clocks. Each one changes at most once per cycle and never at a rising edge of either domain, which lets the two-cycle latency be expressed exactly with `$past`. The stimulus meets this by changing inputs only on CPU falling edges. The PCI clock is offset by half a time unit from these edges, so it never shares an edge with them. The assertions also assume that reset is applied once, from time zero, and never again in the middle of a clock phase. The bench releases reset only once, on a CPU falling edge.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int unsigned CPU_N_DEF = 4;
  localparam int unsigned PCI_N_DEF = 5;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent in the low phase only: enable is frozen across each high phase
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;

  // just before a rising edge the source is low, so the gated clock must be too
  AST_PARK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !gclk_o); // R7
endmodule

// File: rtl/clk_group.sv
module clk_group #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] FREE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  input  logic         stop_i,
  input  logic         tri_i,
  output logic [N-1:0] clk_o,
  output logic [N-1:0] oe_o
);
  logic [N-1:0] en_s;
  logic         stop_s;
  logic         tri_s;
  logic [N-1:0] run;

  sync_2ff #(.W(N), .RST_VAL('0)) u_en_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s)
  );
  sync_2ff #(.W(1), .RST_VAL(1'b0)) u_stop_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_i), .q_o(stop_s)
  );
  sync_2ff #(.W(1), .RST_VAL(1'b1)) u_tri_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tri_i), .q_o(tri_s)
  );

  for (genvar k = 0; k < N; k++) begin : g_out
    if (FREE_MASK[k]) begin : g_free
      assign run[k] = en_s[k];
    end else begin : g_stoppable
      assign run[k] = en_s[k] & ~stop_s;
    end
    clk_gate_cell u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run[k]), .gclk_o(clk_o[k])
    );
  end

  assign oe_o = {N{~tri_s}};

  // cycles since reset, so $past never reaches into reset
  logic [1:0] warm_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end
  logic warm;
  assign warm = (warm_cnt == 2'd2);

  AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> ((run & ~$past(en_i, 2)) == '0)); // R1
  AST_STOP_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(stop_i, 2)) |-> ((run & ~FREE_MASK) == '0)); // R2 R3
  AST_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> ((run & FREE_MASK) == ($past(en_i, 2) & FREE_MASK))); // R4
  AST_OE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (oe_o == {N{~$past(tri_i, 2)}})); // R8
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int unsigned CPU_N = CPU_N_DEF,
  parameter int unsigned PCI_N = PCI_N_DEF
) (
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             rst_ni,
  input  logic             mode_strap_i,
  input  logic             stop_vld_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             tristate_i,
  input  logic [CPU_N-1:0] cpu_en_i,
  input  logic [PCI_N-1:0] pci_en_i,
  input  logic             pci_free_en_i,
  output logic [CPU_N-1:0] cpu_clk_o,
  output logic [CPU_N-1:0] cpu_oe_o,
  output logic [PCI_N-1:0] pci_clk_o,
  output logic [PCI_N-1:0] pci_oe_o,
  output logic             pci_free_clk_o,
  output logic             pci_free_oe_o
);
  localparam int unsigned PCI_ALL = PCI_N + 1;
  localparam logic [PCI_ALL-1:0] PCI_FREE_MASK = {1'b1, {PCI_N{1'b0}}};

  // strap high or invalid flag: stop pins read as deasserted (R5, R6)
  logic stop_honoured;
  logic cpu_stop_req;
  logic pci_stop_req;
  assign stop_honoured = ~mode_strap_i & stop_vld_i;
  assign cpu_stop_req  = stop_honoured & ~cpu_stop_ni;
  assign pci_stop_req  = stop_honoured & ~pci_stop_ni;

  clk_group #(.N(CPU_N), .FREE_MASK('0)) u_cpu_grp (
    .clk_i(cpu_clk_i), .rst_ni(rst_ni), .en_i(cpu_en_i), .stop_i(cpu_stop_req),
    .tri_i(tristate_i), .clk_o(cpu_clk_o), .oe_o(cpu_oe_o)
  );

  logic [PCI_ALL-1:0] pci_clk_all;
  logic [PCI_ALL-1:0] pci_oe_all;

  clk_group #(.N(PCI_ALL), .FREE_MASK(PCI_FREE_MASK)) u_pci_grp (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .en_i({pci_free_en_i, pci_en_i}),
    .stop_i(pci_stop_req), .tri_i(tristate_i), .clk_o(pci_clk_all), .oe_o(pci_oe_all)
  );

  assign pci_clk_o      = pci_clk_all[PCI_N-1:0];
  assign pci_oe_o       = pci_oe_all[PCI_N-1:0];
  assign pci_free_clk_o = pci_clk_all[PCI_N];
  assign pci_free_oe_o  = pci_oe_all[PCI_N];
endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/100ps
module clk_stop_gate_tb;
  localparam int CN = 4;
  localparam int PN = 5;

  logic cpu_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, vld = 1'b0, cstop_n = 1'b1, pstop_n = 1'b1, tri_r = 1'b0;
  logic [CN-1:0] cen = '1;
  logic [PN-1:0] pen = '1;
  logic fen = 1'b1;
  logic [CN-1:0] cclk_o, coe_o;
  logic [PN-1:0] pclk_o, poe_o;
  logic fclk_o, foe_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R9";

  clk_stop_gate u_dut (
    .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .rst_ni(rst_n), .mode_strap_i(mode),
    .stop_vld_i(vld), .cpu_stop_ni(cstop_n), .pci_stop_ni(pstop_n), .tristate_i(tri_r),
    .cpu_en_i(cen), .pci_en_i(pen), .pci_free_en_i(fen),
    .cpu_clk_o(cclk_o), .cpu_oe_o(coe_o), .pci_clk_o(pclk_o), .pci_oe_o(poe_o),
    .pci_free_clk_o(fclk_o), .pci_free_oe_o(foe_o)
  );

  always #2 cpu_clk = ~cpu_clk;
  initial begin
    #0.5;
    forever #3 pci_clk = ~pci_clk;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // reference model: request at edge n shows in high phase after edge n+2, tristate from edge n+1
  logic [CN-1:0] cq[$];
  bit ctq[$];
  always @(posedge cpu_clk) begin
    logic [CN-1:0] r, exp_en;
    bit honoured, t, exp_oe;
    honoured = !mode && vld;
    r = rst_n ? (cen & {CN{!(honoured && !cstop_n)}}) : '0;
    t = rst_n ? tri_r : 1'b1;
    cq.push_back(r);
    ctq.push_back(t);
    exp_en = (cq.size() == 3) ? cq.pop_front() : '0;
    exp_oe = (ctq.size() == 2) ? !ctq.pop_front() : 1'b0;
    #1;
    if (!done && rst_n) begin
      check(tag, 8'(cclk_o), 8'(exp_en));
      check("R8", 8'(coe_o), 8'({CN{exp_oe}}));
    end
  end

  logic [PN:0] pq[$];
  bit ptq[$];
  always @(posedge pci_clk) begin
    logic [PN:0] r, exp_en;
    bit honoured, t, exp_oe;
    honoured = !mode && vld;
    r = rst_n ? {fen, pen & {PN{!(honoured && !pstop_n)}}} : '0;
    t = rst_n ? tri_r : 1'b1;
    pq.push_back(r);
    ptq.push_back(t);
    exp_en = (pq.size() == 3) ? pq.pop_front() : '0;
    exp_oe = (ptq.size() == 2) ? !ptq.pop_front() : 1'b0;
    #1.5;
    if (!done && rst_n) begin
      check(tag, 8'({fclk_o, pclk_o}), 8'(exp_en));
      check("R8", 8'({foe_o, poe_o}), 8'({(PN+1){exp_oe}}));
    end
  end

  // low phase: no output may be high (R7)
  always @(negedge cpu_clk) begin
    #1;
    if (!done) check("R7", 8'(cclk_o), 8'h00);
  end
  always @(negedge pci_clk) begin
    #1.5;
    if (!done) check("R7", 8'({fclk_o, pclk_o}), 8'h00);
  end

  task automatic hold(input int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    hold(2);
    #1;
    // R9: reset state with all enables set
    check("R9", 8'({cclk_o, coe_o}), 8'h00);
    check("R9", 8'({fclk_o, pclk_o}), 8'h00);
    check("R9", 8'({foe_o, poe_o}), 8'h00);
    hold(3);
    rst_n = 1'b1;
    vld = 1'b1;
    tag = "R1";
    hold(12);
    cen = 4'b1010; pen = 5'b10101; hold(12);
    cen = 4'b0101; pen = 5'b01010; fen = 1'b0; hold(12);
    cen = 4'b0000; pen = 5'b00000; hold(10);
    cen = '1; pen = '1; fen = 1'b1; hold(10);
    tag = "R2";
    cstop_n = 1'b0; hold(15);
    cstop_n = 1'b1; hold(10);
    tag = "R3";
    pstop_n = 1'b0; hold(15);
    tag = "R4";
    fen = 1'b0; hold(10);
    fen = 1'b1; hold(10);
    pstop_n = 1'b1; hold(10);
    tag = "R5";
    mode = 1'b1; hold(5);
    cstop_n = 1'b0; pstop_n = 1'b0; hold(15);
    mode = 1'b0; hold(12);
    tag = "R6";
    vld = 1'b0; hold(15);
    vld = 1'b1; hold(10);
    cstop_n = 1'b1; pstop_n = 1'b1; hold(10);
    tag = "R8";
    tri_r = 1'b1; hold(12);
    cen = 4'b0110; hold(8);
    tri_r = 1'b0; hold(12);
    tag = "R1";
    for (int i = 0; i < 16; i++) begin
      cen = 4'(i);
      pen = 5'(i * 3);
      fen = i[0];
      hold(3);
    end
    hold(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule